// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block is the counting core of a real-time clock. It takes a one-cycle tick pulse at the 32.768 kHz slow-clock rate, divides it down to whole seconds and keeps the time of day (seconds, minutes, hours) and the calendar (weekday, day, month, two-digit year for 2000 to 2099) in packed BCD. All carries are handled in hardware, including month lengths and the leap February of every year divisible by four.

Software reaches the block through a simple word-addressed register bus. To set the time it raises a hold request. Counting freezes at once, and a stopped flag confirms the hold within two slow ticks. Software then loads the time and calendar words and drops the request to resume. To read the time it uses snapshot copies that refresh after every second step. It compares the snapshot seconds with a live seconds register to see whether a rollover happened during the read.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the run-control word reads 0, the hold word reads 0, the live and snapshot time words read 0x000000, the live and snapshot calendar words read 0x00010100 (year 00, month 01, day 01, weekday 0), and the live seconds word reads 0.
- R2: The time word holds BCD seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16. The calendar word holds the weekday (0 to 6) in bits 3:0, BCD day in 15:8, BCD month in 23:16 and BCD year in 31:24. The seconds value steps by one after every TICKS_PER_SEC tick pulses counted while running.
- R3: The run-control word (address 0) stores an enable bit at bit 7 and a 24-hour select bit at bit 5, and reads them back in place. While enable is 0, ticks never change the time.
- R4: Writing 1 to bit 0 of the hold word (address 1) sets the hold request and stops counting at once. Bit 1 (stopped) reads 0 after the first later tick and 1 after the second later tick. Ticks have no effect on the time while held.
- R5: Writes to the time word (address 2) and the calendar word (address 3) load the counters only while the hold request or stopped flag is set. At other times they are ignored.
- R6: Writing 0 to the hold word clears both hold bits. Counting resumes from the loaded values, and the sub-second divider restarts from zero after a time load.
- R7: Seconds 59 wraps to 00 and steps minutes, minutes 59 wraps and steps hours, and hours 23 wraps to 00, steps the day and advances the weekday modulo 7 (6 goes to 0). BCD digit carries are correct (09:59:59 becomes 10:00:00).
- R8: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and in February after day 29 when the year is divisible by 4 and after day 28 otherwise.
- R9: Month 12 wraps to 01 and steps the year, and year 99 wraps to 00.
- R10: The snapshot time (address 4) and calendar (address 5) words equal the live counters one cycle after each second step or load. The live seconds word (address 6) returns the running seconds in bits 7:0.
- R11: Read data appears on the bus one cycle after the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at the slow-clock rate |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |

## Verification
The hardest cases to reach are the calendar carries at the ends of the year and of a month, since free counting from reset would take days of simulated time. The bench reaches each one by holding the counter, loading a time of 23:59:59 with a chosen date, releasing the hold and issuing one second of ticks. The divider's reset to zero on load makes the rollover cycle exact. It uses the same hold-and-load route to confirm that loads attempted while running are dropped, and to step the stopped flag one tick at a time.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    typedef struct packed {
        logic [7:0] hr;
        logic [7:0] mn;
        logic [7:0] sc;
    } rtc_tod_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mo;
        logic [7:0] dy;
        logic [3:0] pad;
        logic [3:0] wd;
    } rtc_date_t;

    localparam int REG_RUN       = 0;
    localparam int REG_HOLD      = 1;
    localparam int REG_TOD       = 2;
    localparam int REG_DATE      = 3;
    localparam int REG_SNAP_TOD  = 4;
    localparam int REG_SNAP_DATE = 5;
    localparam int REG_LIVE_SEC  = 6;

    localparam rtc_tod_t  TOD_RESET  = '0;
    localparam rtc_date_t DATE_RESET = '{yr: 8'h00, mo: 8'h01, dy: 8'h01, pad: 4'h0, wd: 4'h0};

    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // year (tens*10+ones) divisible by 4 <=> (2*tens+ones) divisible by 4
    function automatic logic leap_year(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_end(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_rtc_prescale.sv
module bcd_rtc_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic sec_pulse_o
);
    localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    assign wrap        = run_i && tick_i && (cnt_q == PRE_LAST);
    assign sec_pulse_o = wrap;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                cnt_d = '0;
        else if (run_i && tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3 / R4: the divider is frozen whenever counting is not allowed
    a_r3_divider_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(cnt_q));

    // R6: a load restarts the sub-second phase
    a_r6_divider_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bcd_rtc_hold.sv
module bcd_rtc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wr_i,
    input  logic req_i,
    output logic req_o,
    output logic stopped_o
);
    typedef struct packed {
        logic req;
        logic stopped;
        logic seen;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.req = req_i;
            if (!req_i) begin
                st_d.stopped = 1'b0;
                st_d.seen    = 1'b0;
            end
        end else if (st_q.req && !st_q.stopped && tick_i) begin
            if (st_q.seen) st_d.stopped = 1'b1;
            else           st_d.seen    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o     = st_q.req;
    assign stopped_o = st_q.stopped;

    // R4: stopped is only ever reported under a pending request
    a_r4_stopped_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |-> req_o);

    // R4: the stopped flag rises only on a slow tick
    a_r4_stopped_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> $past(tick_i));

    // R6: a release write clears both bits
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !req_i) |=> (!req_o && !stopped_o));
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
    import bcd_rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse_i,
    input  logic        ld_tod_i,
    input  logic        ld_date_i,
    input  logic [31:0] wdata_i,
    output rtc_tod_t    tod_o,
    output rtc_date_t   date_o
);
    typedef struct packed {
        rtc_tod_t  tod;
        rtc_date_t date;
    } cal_st_t;

    cal_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sec_pulse_i) begin
            if (st_q.tod.sc != 8'h59) begin
                st_d.tod.sc = bcd_step(st_q.tod.sc);
            end else begin
                st_d.tod.sc = 8'h00;
                if (st_q.tod.mn != 8'h59) begin
                    st_d.tod.mn = bcd_step(st_q.tod.mn);
                end else begin
                    st_d.tod.mn = 8'h00;
                    if (st_q.tod.hr != 8'h23) begin
                        st_d.tod.hr = bcd_step(st_q.tod.hr);
                    end else begin
                        st_d.tod.hr  = 8'h00;
                        st_d.date.wd = (st_q.date.wd >= 4'd6) ? 4'd0 : st_q.date.wd + 4'd1;
                        if (st_q.date.dy != month_end(st_q.date.mo, st_q.date.yr)) begin
                            st_d.date.dy = bcd_step(st_q.date.dy);
                        end else begin
                            st_d.date.dy = 8'h01;
                            if (st_q.date.mo != 8'h12) begin
                                st_d.date.mo = bcd_step(st_q.date.mo);
                            end else begin
                                st_d.date.mo = 8'h01;
                                st_d.date.yr = (st_q.date.yr == 8'h99) ? 8'h00 : bcd_step(st_q.date.yr);
                            end
                        end
                    end
                end
            end
        end
        if (ld_tod_i)  st_d.tod  = wdata_i[23:0];
        if (ld_date_i) st_d.date = {wdata_i[31:8], 4'h0, wdata_i[3:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tod: TOD_RESET, date: DATE_RESET};
        else        st_q <= st_d;
    end

    assign tod_o  = st_q.tod;
    assign date_o = st_q.date;

    // R4 / R5: nothing moves without a second step or a load
    a_r5_counters_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse_i && !ld_tod_i && !ld_date_i) |=> ($stable(tod_o) && $stable(date_o)));

    // R7: seconds wrap carries into minutes
    a_r7_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse_i && !ld_tod_i && tod_o.sc == 8'h59) |=> (tod_o.sc == 8'h00 && !$stable(tod_o.mn)));

    // R9: last second of the century wraps the year
    a_r9_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse_i && !ld_tod_i && !ld_date_i && tod_o == 24'h235959 &&
         date_o.mo == 8'h12 && date_o.dy == 8'h31 && date_o.yr == 8'h99)
        |=> (date_o.yr == 8'h00 && date_o.mo == 8'h01 && date_o.dy == 8'h01));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int ADDR_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o
);
    localparam int EN_BIT  = 7;
    localparam int M24_BIT = 5;

    typedef struct packed {
        logic        en;
        logic        m24;
        rtc_tod_t    snap_tod;
        rtc_date_t   snap_date;
        logic        upd;
        logic [31:0] rdata;
    } core_st_t;

    core_st_t  st_d, st_q;
    logic      hold_req, hold_stopped, held, run;
    logic      wr_run, wr_hold, ld_tod, ld_date, sec_pulse;
    rtc_tod_t  tod;
    rtc_date_t date;
    logic [31:0] rd_mux;

    assign held    = hold_req || hold_stopped;
    assign run     = st_q.en && !held;
    assign wr_run  = bus_wr_i && (bus_addr_i == ADDR_W'(REG_RUN));
    assign wr_hold = bus_wr_i && (bus_addr_i == ADDR_W'(REG_HOLD));
    assign ld_tod  = bus_wr_i && held && (bus_addr_i == ADDR_W'(REG_TOD));
    assign ld_date = bus_wr_i && held && (bus_addr_i == ADDR_W'(REG_DATE));

    bcd_rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
        .clr_i(ld_tod), .sec_pulse_o(sec_pulse)
    );

    bcd_rtc_hold u_hold (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_hold),
        .req_i(bus_wdata_i[0]), .req_o(hold_req), .stopped_o(hold_stopped)
    );

    bcd_rtc_calendar u_calendar (
        .clk(clk), .rst_n(rst_n), .sec_pulse_i(sec_pulse), .ld_tod_i(ld_tod),
        .ld_date_i(ld_date), .wdata_i(bus_wdata_i), .tod_o(tod), .date_o(date)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr_i)
            ADDR_W'(REG_RUN): begin
                rd_mux[EN_BIT]  = st_q.en;
                rd_mux[M24_BIT] = st_q.m24;
            end
            ADDR_W'(REG_HOLD):      rd_mux[1:0] = {hold_stopped, hold_req};
            ADDR_W'(REG_TOD):       rd_mux = {8'h00, tod};
            ADDR_W'(REG_DATE):      rd_mux = date;
            ADDR_W'(REG_SNAP_TOD):  rd_mux = {8'h00, st_q.snap_tod};
            ADDR_W'(REG_SNAP_DATE): rd_mux = st_q.snap_date;
            ADDR_W'(REG_LIVE_SEC):  rd_mux[7:0] = tod.sc;
            default:                rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = sec_pulse || ld_tod || ld_date;
        if (wr_run) begin
            st_d.en  = bus_wdata_i[EN_BIT];
            st_d.m24 = bus_wdata_i[M24_BIT];
        end
        if (st_q.upd) begin
            st_d.snap_tod  = tod;
            st_d.snap_date = date;
        end
        if (bus_rd_i) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, m24: 1'b0, snap_tod: TOD_RESET,
                              snap_date: DATE_RESET, upd: 1'b0, rdata: 32'h0};
        else        st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;

    // R3: no second step while the enable bit is clear
    a_r3_no_step_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> !sec_pulse);

    // R4: no second step while held
    a_r4_no_step_held: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !sec_pulse);

    // R10: snapshot tracks the live counters after an update
    a_r10_snap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd && !sec_pulse && !ld_tod && !ld_date) |=>
        (st_q.snap_tod == tod && st_q.snap_date == date));

    // R11: read data holds between read strobes
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int TPS    = 4;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic              bus_rd_i = 1'b0;
    logic [ADDR_W-1:0] bus_addr_i = '0;
    logic [31:0]       bus_wdata_i = '0;
    logic [31:0]       bus_rdata_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_rtc_core #(.TICKS_PER_SEC(TPS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
        .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr_i    = 1'b1;
        bus_addr_i  = ADDR_W'(addr);
        bus_wdata_i = data;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd_i   = 1'b1;
        bus_addr_i = ADDR_W'(addr);
        @(negedge clk);
        bus_rd_i = 1'b0;
        data = bus_rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic expect_reg(input string req, input int addr, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(addr, v);
        check(req, v, exp);
    endtask

    task automatic load_clock(input logic [31:0] tod, input logic [31:0] date);
        bus_write(1, 32'h1);
        bus_write(2, tod);
        bus_write(3, date);
        bus_write(1, 32'h0);
    endtask

    task automatic t_reset;
        expect_reg("R1 run word", 0, 32'h0);
        expect_reg("R1 hold word", 1, 32'h0);
        expect_reg("R1 time", 2, 32'h0);
        expect_reg("R1 calendar", 3, 32'h00010100);
        expect_reg("R1 snap time", 4, 32'h0);
        expect_reg("R1 snap calendar", 5, 32'h00010100);
        expect_reg("R1 live sec", 6, 32'h0);
    endtask

    task automatic t_disabled;
        ticks(3 * TPS);
        expect_reg("R3 no count while disabled", 2, 32'h0);
        bus_write(0, 32'hA0);
        expect_reg("R3 run word readback", 0, 32'hA0);
    endtask

    task automatic t_ignored_load;
        bus_write(2, 32'h123456);
        bus_write(3, 32'h45061503);
        expect_reg("R5 time write ignored when running", 2, 32'h0);
        expect_reg("R5 calendar write ignored when running", 3, 32'h00010100);
    endtask

    task automatic t_hold;
        bus_write(1, 32'h1);
        expect_reg("R4 request set, not stopped", 1, 32'h1);
        ticks(1);
        expect_reg("R4 one tick, not stopped", 1, 32'h1);
        ticks(1);
        expect_reg("R4 stopped after two ticks", 1, 32'h3);
        ticks(2 * TPS);
        expect_reg("R4 no count while held", 2, 32'h0);
    endtask

    task automatic t_year_end;
        bus_write(2, 32'h235958);
        bus_write(3, 32'h99123106);
        expect_reg("R5 time loaded while held", 2, 32'h235958);
        expect_reg("R2 calendar loaded while held", 3, 32'h99123106);
        bus_write(1, 32'h0);
        expect_reg("R6 release clears hold", 1, 32'h0);
        ticks(TPS - 1);
        expect_reg("R6 divider restarted", 2, 32'h235958);
        ticks(1);
        expect_reg("R2 second step", 2, 32'h235959);
        ticks(TPS);
        expect_reg("R7 midnight wrap", 2, 32'h0);
        expect_reg("R9 year and month wrap, weekday 6 to 0", 3, 32'h00010100);
        expect_reg("R10 snap time", 4, 32'h0);
        expect_reg("R10 snap calendar", 5, 32'h00010100);
        expect_reg("R10 live sec", 6, 32'h0);
    endtask

    task automatic t_month(input string req, input logic [31:0] date_in, input logic [31:0] date_exp);
        load_clock(32'h235959, date_in);
        ticks(TPS);
        expect_reg(req, 3, date_exp);
    endtask

    task automatic t_hour_carry;
        load_clock(32'h095959, 32'h23061504);
        ticks(TPS);
        expect_reg("R7 BCD hour carry", 2, 32'h100000);
        ticks(TPS);
        expect_reg("R10 live sec after step", 6, 32'h01);
        expect_reg("R10 snap follows step", 4, 32'h100001);
    endtask

    task automatic t_rdata_hold;
        logic [31:0] v;
        bus_read(6, v);
        bus_write(0, 32'h80);
        ticks(TPS);
        @(negedge clk);
        check("R11 read data holds", bus_rdata_o, v);
        expect_reg("R3 mode bit cleared", 0, 32'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_ignored_load();
        t_hold();
        t_year_end();
        t_month("R8 Feb 28 leap year", 32'h24022802, 32'h24022903);
        t_month("R8 Feb 29 leap year", 32'h24022902, 32'h24030103);
        t_month("R8 Feb 28 common year", 32'h23022802, 32'h23030103);
        t_month("R8 Apr 30", 32'h23043002, 32'h23050103);
        t_month("R8 Nov 30", 32'h23113002, 32'h23120103);
        t_month("R8 Jan 30", 32'h23013002, 32'h23013103);
        t_month("R8 Jul 31", 32'h23073102, 32'h23080103);
        t_hour_carry();
        t_rdata_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule